// File: doc/BRIEF.md
# Byte-Order Swapping Data Buffer

This block is the data staging store that sits between a 16-bit register data port and a byte-serial bus sequencer. Register-side halfword writes, and a single trailing byte write, pack transmit bytes into a four-slot word. The sequencer pops transmit bytes oldest first and pushes received bytes into the same word. Register-side halfword reads then drain the received bytes two at a time. A control input chooses how the two bytes of a halfword map onto byte slots.

The block keeps separate transmit and receive byte counts and reports each status change as a one-cycle event pulse (clear underflow, clear transmit-ready, clear receive-ready, clear overrun, set single-byte, set access-ready, clear master, re-run sequencer). The status register that these pulses act on belongs to the surrounding controller. At most one operation is applied per cycle, chosen by a fixed priority.

Top module: `byteswap_pack_buf`

## Requirements
- R1: After reset both byte counts are 0, the stored word is 0, and no event output is high while all request inputs are low.
- R2: A halfword write with a transmit count of 2 or less shifts the word left by 16 bits, places the new halfword in bits 15:0 and adds 2 to the transmit count. With a count above 2 the write changes nothing and raises no event.
- R3: With `order_keep_i` = 0, write data bits 7:0 land in word bits 15:8 and data bits 15:8 land in word bits 7:0. With `order_keep_i` = 1 the halfword is stored as written.
- R4: A byte write with a transmit count of 2 or less shifts the word left by 8 bits, places data bits 7:0 in word bits 7:0 and adds 1 to the transmit count. With a count above 2 it changes nothing.
- R5: In the cycle of an accepted write, `underflow_clr_o` and `seq_kick_o` are high. `tx_ready_clr_o` is high as well when the resulting transmit count exceeds 2.
- R6: `tx_byte_o` shows word bits [(n-1)*8 +: 8], where n is the transmit count. A pop lowers n by 1, and a pop with n = 0 is ignored.
- R7: A push writes `rx_byte_i` into word bits [m*8 +: 8], where m is the receive count, and raises m by 1. A push with m = 4 is ignored.
- R8: `rd_data_o` carries word bits 15:8 in its upper byte and bits 7:0 in its lower byte when `order_keep_i` = 0. When `order_keep_i` = 1 the two bytes trade places.
- R9: A read with a receive count of 1 pulses `single_byte_set_o` and sets the count to 0, leaving the word unchanged.
- R10: A read with a receive count of 2 or more lowers the count by 2. The word shifts right by 16 bits only when the count was above 2.
- R11: A read that leaves the receive count at 0 pulses `rx_ready_clr_o`; with `mst_rx_i` high it also pulses `access_ready_set_o` and `master_clr_o`. A read at count 0 leaves the count and the word unchanged.
- R12: Every applied read pulses `overrun_clr_o` and `seq_kick_o`.
- R13: Only one request is applied per cycle, in the priority order halfword write, byte write, read, pop, push. The lower-priority requests in that cycle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| order_keep_i | input | 1 | 1: halfword stored and read unswapped; 0: bytes swapped |
| mst_rx_i | input | 1 | Controller is currently a master receiver |
| wr_half_i | input | 1 | Halfword write request |
| wr_byte_i | input | 1 | Final byte write request |
| wr_data_i | input | 16 | Write data |
| rd_i | input | 1 | Halfword read request |
| rd_data_o | output | 16 | Read data view of the lowest two byte slots |
| tx_pop_i | input | 1 | Sequencer takes one transmit byte |
| tx_byte_o | output | 8 | Next transmit byte |
| tx_count_o | output | 3 | Pending transmit bytes |
| rx_push_i | input | 1 | Sequencer delivers one received byte |
| rx_byte_i | input | 8 | Received byte |
| rx_count_o | output | 3 | Buffered received bytes |
| underflow_clr_o | output | 1 | Clear transmit-underflow status |
| tx_ready_clr_o | output | 1 | Clear transmit-ready status |
| rx_ready_clr_o | output | 1 | Clear receive-ready status |
| overrun_clr_o | output | 1 | Clear receive-overrun status |
| single_byte_set_o | output | 1 | Set single-byte status |
| access_ready_set_o | output | 1 | Set access-ready status |
| master_clr_o | output | 1 | Drop master mode |
| seq_kick_o | output | 1 | Re-run the transfer sequencer |

## Verification
A wrong byte count shows up in the same cycle as a misplaced rejection or a missing event pulse. It also shows up when the next pop selects the wrong slot, so a count error becomes visible within one operation. A wrong swap or shift in the word reaches the ports only when the affected slot is popped or read, which can be several operations later. For that reason every transmit sequence is drained completely and every receive sequence is read to empty, with each byte compared. Stale upper slots are exposed by reading again after the count reaches zero or one.

// File: rtl/bsb_pkg.sv
package bsb_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_WR_HALF,
    OP_WR_BYTE,
    OP_READ,
    OP_POP,
    OP_PUSH
  } bsb_op_e;
endpackage

// File: rtl/bsb_wr_pack.sv
module bsb_wr_pack #(
  parameter int BYTE_W    = 8,
  parameter int NUM_SLOTS = 4,
  localparam int HALF_W = 2 * BYTE_W,
  localparam int WORD_W = BYTE_W * NUM_SLOTS,
  localparam int CNT_W  = $clog2(NUM_SLOTS + 1)
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [HALF_W-1:0] data_i,
  input  logic              keep_order_i,
  input  logic              byte_mode_i,
  output logic              ok_o,
  output logic [WORD_W-1:0] word_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              over_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(NUM_SLOTS - 2);

  // halfword-to-slot mapping; a swap is its own inverse
  function automatic logic [HALF_W-1:0] place_half(input logic [HALF_W-1:0] d,
                                                   input logic keep);
    return keep ? d : {d[BYTE_W-1:0], d[HALF_W-1:BYTE_W]};
  endfunction

  always_comb begin
    ok_o = (cnt_i <= LIMIT);
    if (byte_mode_i) begin
      word_o = {word_i[WORD_W-BYTE_W-1:0], data_i[BYTE_W-1:0]};
      cnt_o  = cnt_i + CNT_W'(1);
    end else begin
      word_o = {word_i[WORD_W-HALF_W-1:0], place_half(data_i, keep_order_i)};
      cnt_o  = cnt_i + CNT_W'(2);
    end
    over_o = (cnt_o > LIMIT);
  end
endmodule

// File: rtl/bsb_rd_unpack.sv
module bsb_rd_unpack #(
  parameter int BYTE_W    = 8,
  parameter int NUM_SLOTS = 4,
  localparam int HALF_W = 2 * BYTE_W,
  localparam int WORD_W = BYTE_W * NUM_SLOTS,
  localparam int CNT_W  = $clog2(NUM_SLOTS + 1)
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              keep_order_i,
  input  logic              mst_rx_i,
  output logic [HALF_W-1:0] data_o,
  output logic [WORD_W-1:0] word_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              single_o,
  output logic              empty_o,
  output logic              ardy_o
);
  function automatic logic [HALF_W-1:0] view_half(input logic [WORD_W-1:0] w,
                                                  input logic keep);
    logic [BYTE_W-1:0] b0, b1;
    b0 = w[BYTE_W-1:0];
    b1 = w[HALF_W-1:BYTE_W];
    return keep ? {b0, b1} : {b1, b0};
  endfunction

  assign data_o = view_half(word_i, keep_order_i);

  always_comb begin
    word_o   = word_i;
    cnt_o    = cnt_i;
    single_o = 1'b0;
    if (cnt_i == CNT_W'(1)) begin
      single_o = 1'b1;
      cnt_o    = '0;
    end else if (cnt_i > CNT_W'(1)) begin
      if (cnt_i > CNT_W'(2)) word_o = word_i >> HALF_W;
      cnt_o = cnt_i - CNT_W'(2);
    end
    empty_o = (cnt_o == '0);
    ardy_o  = empty_o & mst_rx_i;
  end
endmodule

// File: rtl/bsb_seq_port.sv
module bsb_seq_port #(
  parameter int BYTE_W    = 8,
  parameter int NUM_SLOTS = 4,
  localparam int WORD_W = BYTE_W * NUM_SLOTS,
  localparam int CNT_W  = $clog2(NUM_SLOTS + 1)
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [CNT_W-1:0]  tx_cnt_i,
  input  logic [CNT_W-1:0]  rx_cnt_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  output logic [BYTE_W-1:0] tx_byte_o,
  output logic              pop_ok_o,
  output logic              push_ok_o,
  output logic [WORD_W-1:0] push_word_o
);
  function automatic logic [BYTE_W-1:0] slot_get(input logic [WORD_W-1:0] w,
                                                 input logic [CNT_W-1:0] idx);
    logic [BYTE_W-1:0] r;
    r = '0;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (int'(idx) == s) r = w[s*BYTE_W +: BYTE_W];
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] slot_put(input logic [WORD_W-1:0] w,
                                                 input logic [CNT_W-1:0] idx,
                                                 input logic [BYTE_W-1:0] b);
    logic [WORD_W-1:0] r;
    r = w;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (int'(idx) == s) r[s*BYTE_W +: BYTE_W] = b;
    return r;
  endfunction

  assign pop_ok_o    = (tx_cnt_i != '0);
  assign push_ok_o   = (rx_cnt_i < CNT_W'(NUM_SLOTS));
  assign tx_byte_o   = pop_ok_o ? slot_get(word_i, tx_cnt_i - CNT_W'(1)) : '0;
  assign push_word_o = slot_put(word_i, rx_cnt_i, rx_byte_i);
endmodule

// File: rtl/byteswap_pack_buf.sv
module byteswap_pack_buf #(
  parameter int BYTE_W    = 8,
  parameter int NUM_SLOTS = 4,
  localparam int HALF_W = 2 * BYTE_W,
  localparam int WORD_W = BYTE_W * NUM_SLOTS,
  localparam int CNT_W  = $clog2(NUM_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              order_keep_i,
  input  logic              mst_rx_i,
  input  logic              wr_half_i,
  input  logic              wr_byte_i,
  input  logic [HALF_W-1:0] wr_data_i,
  input  logic              rd_i,
  output logic [HALF_W-1:0] rd_data_o,
  input  logic              tx_pop_i,
  output logic [BYTE_W-1:0] tx_byte_o,
  output logic [CNT_W-1:0]  tx_count_o,
  input  logic              rx_push_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  output logic [CNT_W-1:0]  rx_count_o,
  output logic              underflow_clr_o,
  output logic              tx_ready_clr_o,
  output logic              rx_ready_clr_o,
  output logic              overrun_clr_o,
  output logic              single_byte_set_o,
  output logic              access_ready_set_o,
  output logic              master_clr_o,
  output logic              seq_kick_o
);
  import bsb_pkg::*;

  logic [WORD_W-1:0] word_q, word_d;
  logic [CNT_W-1:0]  tx_cnt_q, tx_cnt_d, rx_cnt_q, rx_cnt_d;
  bsb_op_e           op;

  logic              wr_ok, wr_over;
  logic [WORD_W-1:0] wr_word;
  logic [CNT_W-1:0]  wr_cnt;
  logic [WORD_W-1:0] rd_word;
  logic [CNT_W-1:0]  rd_cnt;
  logic              rd_single, rd_empty, rd_ardy;
  logic              pop_ok, push_ok;
  logic [WORD_W-1:0] push_word;

  // named events for the checker
  logic              wr_accepted, rd_applied;

  // fixed priority: one request per cycle
  always_comb begin
    if (wr_half_i)      op = OP_WR_HALF;
    else if (wr_byte_i) op = OP_WR_BYTE;
    else if (rd_i)      op = OP_READ;
    else if (tx_pop_i)  op = OP_POP;
    else if (rx_push_i) op = OP_PUSH;
    else                op = OP_IDLE;
  end

  bsb_wr_pack #(.BYTE_W(BYTE_W), .NUM_SLOTS(NUM_SLOTS)) u_wr (
    .word_i(word_q), .cnt_i(tx_cnt_q), .data_i(wr_data_i),
    .keep_order_i(order_keep_i), .byte_mode_i(op == OP_WR_BYTE),
    .ok_o(wr_ok), .word_o(wr_word), .cnt_o(wr_cnt), .over_o(wr_over)
  );

  bsb_rd_unpack #(.BYTE_W(BYTE_W), .NUM_SLOTS(NUM_SLOTS)) u_rd (
    .word_i(word_q), .cnt_i(rx_cnt_q), .keep_order_i(order_keep_i),
    .mst_rx_i(mst_rx_i), .data_o(rd_data_o), .word_o(rd_word),
    .cnt_o(rd_cnt), .single_o(rd_single), .empty_o(rd_empty), .ardy_o(rd_ardy)
  );

  bsb_seq_port #(.BYTE_W(BYTE_W), .NUM_SLOTS(NUM_SLOTS)) u_seq (
    .word_i(word_q), .tx_cnt_i(tx_cnt_q), .rx_cnt_i(rx_cnt_q),
    .rx_byte_i(rx_byte_i), .tx_byte_o(tx_byte_o), .pop_ok_o(pop_ok),
    .push_ok_o(push_ok), .push_word_o(push_word)
  );

  assign wr_accepted = ((op == OP_WR_HALF) || (op == OP_WR_BYTE)) && wr_ok;
  assign rd_applied  = (op == OP_READ);

  always_comb begin
    word_d   = word_q;
    tx_cnt_d = tx_cnt_q;
    rx_cnt_d = rx_cnt_q;
    unique case (op)
      OP_WR_HALF, OP_WR_BYTE: if (wr_ok) begin
        word_d   = wr_word;
        tx_cnt_d = wr_cnt;
      end
      OP_READ: begin
        word_d   = rd_word;
        rx_cnt_d = rd_cnt;
      end
      OP_POP:  if (pop_ok) tx_cnt_d = tx_cnt_q - CNT_W'(1);
      OP_PUSH: if (push_ok) begin
        word_d   = push_word;
        rx_cnt_d = rx_cnt_q + CNT_W'(1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      tx_cnt_q <= '0;
      rx_cnt_q <= '0;
    end else begin
      word_q   <= word_d;
      tx_cnt_q <= tx_cnt_d;
      rx_cnt_q <= rx_cnt_d;
    end
  end

  assign tx_count_o         = tx_cnt_q;
  assign rx_count_o         = rx_cnt_q;
  assign underflow_clr_o    = wr_accepted;
  assign tx_ready_clr_o     = wr_accepted & wr_over;
  assign overrun_clr_o      = rd_applied;
  assign rx_ready_clr_o     = rd_applied & rd_empty;
  assign single_byte_set_o  = rd_applied & rd_single;
  assign access_ready_set_o = rd_applied & rd_ardy;
  assign master_clr_o       = rd_applied & rd_ardy;
  assign seq_kick_o         = wr_accepted | rd_applied;
endmodule

// File: rtl/bsb_chk.sv
module bsb_chk #(
  parameter int CNT_W     = 3,
  parameter int NUM_SLOTS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_half_i,
  input logic             wr_byte_i,
  input logic             rd_i,
  input logic             tx_pop_i,
  input logic [CNT_W-1:0] tx_count_o,
  input logic [CNT_W-1:0] rx_count_o,
  input logic             underflow_clr_o,
  input logic             rx_ready_clr_o,
  input logic             overrun_clr_o,
  input logic             single_byte_set_o,
  input logic             access_ready_set_o,
  input logic             seq_kick_o
);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(NUM_SLOTS - 2);

  // R2
  half_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_half_i && tx_count_o > LIM |=> tx_count_o == $past(tx_count_o));
  // R2
  half_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_half_i && tx_count_o <= LIM |=> tx_count_o == $past(tx_count_o) + CNT_W'(2));
  // R4
  byte_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_half_i && wr_byte_i && tx_count_o > LIM |-> !underflow_clr_o);
  // R9
  single_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    single_byte_set_o |=> rx_count_o == '0);
  // R11
  ardy_with_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    access_ready_set_o |-> rx_ready_clr_o);
  // R12
  read_events_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i && !wr_half_i && !wr_byte_i |-> overrun_clr_o && seq_kick_o);
  // R6
  pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop_i && !wr_half_i && !wr_byte_i && !rd_i && tx_count_o != '0
    |=> tx_count_o == $past(tx_count_o) - CNT_W'(1));
  // R7
  rx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count_o <= CNT_W'(NUM_SLOTS));
endmodule

bind byteswap_pack_buf bsb_chk #(.CNT_W(CNT_W), .NUM_SLOTS(NUM_SLOTS)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_half_i(wr_half_i), .wr_byte_i(wr_byte_i),
  .rd_i(rd_i), .tx_pop_i(tx_pop_i), .tx_count_o(tx_count_o),
  .rx_count_o(rx_count_o), .underflow_clr_o(underflow_clr_o),
  .rx_ready_clr_o(rx_ready_clr_o), .overrun_clr_o(overrun_clr_o),
  .single_byte_set_o(single_byte_set_o),
  .access_ready_set_o(access_ready_set_o), .seq_kick_o(seq_kick_o)
);

// File: tb/byteswap_pack_buf_tb_top.sv
`timescale 1ns/1ps
module byteswap_pack_buf_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic order_keep = 1'b0, mst_rx = 1'b0;
  logic wr_half = 1'b0, wr_byte = 1'b0, rd = 1'b0, pop = 1'b0, push = 1'b0;
  logic [15:0] wr_data = '0;
  logic [7:0]  rx_byte = '0;
  logic [15:0] rd_data;
  logic [7:0]  tx_byte;
  logic [2:0]  tx_cnt, rx_cnt;
  logic e_und, e_txr, e_rxr, e_ovr, e_sbd, e_ard, e_mcl, e_kick;

  int n_chk = 0;
  int n_bad = 0;

  // captured during the operation cycle
  logic c_und, c_txr, c_rxr, c_ovr, c_sbd, c_ard, c_mcl, c_kick;
  logic [15:0] c_rd;
  logic [7:0]  c_tb;

  always #2.5 clk = ~clk;

  byteswap_pack_buf dut_i (
    .clk(clk), .rst_n(rst_n), .order_keep_i(order_keep), .mst_rx_i(mst_rx),
    .wr_half_i(wr_half), .wr_byte_i(wr_byte), .wr_data_i(wr_data),
    .rd_i(rd), .rd_data_o(rd_data), .tx_pop_i(pop), .tx_byte_o(tx_byte),
    .tx_count_o(tx_cnt), .rx_push_i(push), .rx_byte_i(rx_byte),
    .rx_count_o(rx_cnt), .underflow_clr_o(e_und), .tx_ready_clr_o(e_txr),
    .rx_ready_clr_o(e_rxr), .overrun_clr_o(e_ovr),
    .single_byte_set_o(e_sbd), .access_ready_set_o(e_ard),
    .master_clr_o(e_mcl), .seq_kick_o(e_kick)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic cyc(input logic wh, input logic wb, input logic r, input logic p,
                     input logic ps, input logic [15:0] d, input logic [7:0] b);
    wr_half = wh; wr_byte = wb; rd = r; pop = p; push = ps;
    wr_data = d; rx_byte = b;
    #1;
    c_und = e_und; c_txr = e_txr; c_rxr = e_rxr; c_ovr = e_ovr;
    c_sbd = e_sbd; c_ard = e_ard; c_mcl = e_mcl; c_kick = e_kick;
    c_rd = rd_data; c_tb = tx_byte;
    @(negedge clk);
    wr_half = 0; wr_byte = 0; rd = 0; pop = 0; push = 0;
  endtask

  task automatic do_half(input logic [15:0] d); cyc(1,0,0,0,0,d,8'h00); endtask
  task automatic do_byte(input logic [15:0] d); cyc(0,1,0,0,0,d,8'h00); endtask
  task automatic do_read();                     cyc(0,0,1,0,0,16'h0,8'h00); endtask
  task automatic do_pop();                      cyc(0,0,0,1,0,16'h0,8'h00); endtask
  task automatic do_push(input logic [7:0] b);  cyc(0,0,0,0,1,16'h0,b); endtask

  task automatic t_reset();
    chk("R1 tx count", tx_cnt, 0);
    chk("R1 rx count", rx_cnt, 0);
    chk("R1 word", rd_data, 16'h0000);
    chk("R1 events", {e_und,e_txr,e_rxr,e_ovr,e_sbd,e_ard,e_mcl,e_kick}, 0);
  endtask

  task automatic t_half_swapped();
    order_keep = 0;
    do_half(16'h1234);
    chk("R5 underflow clr", c_und, 1);
    chk("R5 kick", c_kick, 1);
    chk("R5 no txready clr at 2", c_txr, 0);
    chk("R2 count +2", tx_cnt, 2);
    do_pop();
    chk("R3 low byte in upper slot", c_tb, 8'h34);
    chk("R6 count -1", tx_cnt, 1);
    do_pop();
    chk("R3 high byte in lower slot", c_tb, 8'h12);
    do_pop();
    chk("R6 pop at zero ignored", tx_cnt, 0);
  endtask

  task automatic t_half_keep_reject();
    order_keep = 1;
    do_half(16'hABCD);
    do_half(16'h5566);
    chk("R5 txready clr above 2", c_txr, 1);
    chk("R2 count 4", tx_cnt, 4);
    do_half(16'h7788);
    chk("R2 rejected no event", {c_und, c_kick}, 0);
    chk("R2 rejected count", tx_cnt, 4);
    do_pop(); chk("R6 slot3", c_tb, 8'hAB);
    do_pop(); chk("R3 unswapped slot2", c_tb, 8'hCD);
    do_pop(); chk("R6 slot1", c_tb, 8'h55);
    do_pop(); chk("R6 slot0", c_tb, 8'h66);
    chk("R6 drained", tx_cnt, 0);
  endtask

  task automatic t_byte();
    order_keep = 0;
    do_half(16'h0201);
    do_byte(16'h99EE);
    chk("R4 count +1", tx_cnt, 3);
    chk("R5 txready clr on byte", c_txr, 1);
    do_byte(16'h00FF);
    chk("R4 byte rejected count", tx_cnt, 3);
    chk("R4 byte rejected event", c_und, 0);
    do_pop(); chk("R4 slot2", c_tb, 8'h01);
    do_pop(); chk("R4 slot1", c_tb, 8'h02);
    do_pop(); chk("R4 last byte slot0", c_tb, 8'hEE);
  endtask

  task automatic t_rx_read();
    order_keep = 0; mst_rx = 1;
    do_push(8'h11); do_push(8'h22); do_push(8'h33); do_push(8'h44);
    chk("R7 count 4", rx_cnt, 4);
    do_push(8'h55);
    chk("R7 push when full ignored", rx_cnt, 4);
    do_read();
    chk("R8 swapped view", c_rd, 16'h2211);
    chk("R12 overrun clr and kick", {c_ovr, c_kick}, 2'b11);
    chk("R10 not empty", {c_rxr, c_sbd}, 0);
    chk("R10 count -2", rx_cnt, 2);
    order_keep = 1;
    do_read();
    chk("R8 unswapped view after shift", c_rd, 16'h3344);
    chk("R11 empty events master rx", {c_rxr, c_ard, c_mcl}, 3'b111);
    chk("R10 count 0", rx_cnt, 0);
    mst_rx = 0;
    do_read();
    chk("R11 read at zero data", c_rd, 16'h3344);
    chk("R11 read at zero events", {c_rxr, c_ard, c_mcl, c_sbd}, 4'b1000);
    chk("R11 read at zero count", rx_cnt, 0);
  endtask

  task automatic t_single();
    order_keep = 0;
    do_push(8'h5A);
    do_read();
    chk("R9 data", c_rd, 16'h445A);
    chk("R9 single flag", c_sbd, 1);
    chk("R9 count", rx_cnt, 0);
    do_read();
    chk("R9 word unchanged", c_rd, 16'h445A);
    do_push(8'h61); do_push(8'h62); do_push(8'h63);
    do_read();
    chk("R10 three bytes data", c_rd, 16'h6261);
    chk("R10 three to one", rx_cnt, 1);
    do_read();
    chk("R10 shifted by 16", c_rd, 16'h0063);
    chk("R9 single after odd", c_sbd, 1);
  endtask

  task automatic t_priority();
    cyc(1,0,1,0,0,16'hC0DE,8'h00);
    chk("R13 write over read count", tx_cnt, 2);
    chk("R13 read suppressed", c_ovr, 0);
    cyc(0,0,1,1,0,16'h0,8'h00);
    chk("R13 read over pop", tx_cnt, 2);
    cyc(0,0,0,1,1,16'h0,8'h77);
    chk("R13 pop applied", tx_cnt, 1);
    chk("R13 push suppressed", rx_cnt, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_half_swapped();
    t_half_keep_reject();
    t_byte();
    t_rx_read();
    t_single();
    t_priority();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule